// File: doc/BRIEF.md
# Variable-Length Instruction Prefix Decoder

This block fetches one instruction byte by byte through a byte-wide memory port, starting at a given program counter. The first byte is examined. If its three lowest bits are all ones, it is an optional size prefix: it selects an operand size of 1, 2, 4 or 8 bytes, and the opcode follows in the next byte. Any other first byte is itself the opcode, and the size defaults to one byte.

Once the opcode is held, an external opcode table returns an addressing mode. The decoder samples that mode and fetches the operand bytes that follow. It assembles them least significant byte first. For the indexed modes it adds the X or Y index value.

When all outputs are stable, the block pulses `done_o`. At that point it reports:
- the opcode;
- the prefix with its marker bits cleared;
- the operand size;
- the operand or effective address;
- the total instruction length and the program counter of the next instruction.

Top module: `insn_prefix_decoder`

## Requirements
- R1: While `rst_ni` is low, and after it is released, the block is idle: `busy_o`, `done_o`, `mem_req_o` and `opcode_valid_o` are all low.
- R2: A first byte whose bits 2:0 equal 3'b111 is taken as a prefix. The opcode is then read from the following address, and the prefix counts as one byte of the instruction length.
- R3: A first byte whose bits 2:0 are not 3'b111 is the opcode. In that case `size_o` is 1 and `prefix_o` is 0.
- R4: With a prefix, `size_o` equals 1 shifted left by prefix bits 5:4. For example 8'h07 gives 1, 8'h17 gives 2, 8'h27 gives 4 and 8'h37 or 8'hF7 gives 8.
- R5: `prefix_o` is the prefix byte minus 7, which is the byte with bits 2:0 cleared.
- R6: Mode 3'd1 (immediate) fetches `size_o` operand bytes. Mode 3'd0, and the unused codes 3'd6 and 3'd7, fetch none, and `operand_o` is 0.
- R7: Mode 3'd2 (absolute) fetches 8 operand bytes, least significant first, whatever the prefix size.
- R8: Modes 3'd3, 3'd4 and 3'd5 fetch a 4-byte little-endian address and zero-extend it. Mode 3'd4 adds `idx_x_i` and mode 3'd5 adds `idx_y_i` as full-width sums. Mode 3'd3 adds nothing.
- R9: `length_o` is the prefix bytes plus one opcode byte plus the operand bytes. `next_pc_o` equals the start PC plus `length_o`.
- R10: Bytes are read from consecutive addresses starting at the PC, one per cycle in which `mem_req_o` and `mem_valid_i` are both high. While `mem_valid_i` is low, the request and the address are held.
- R11: `done_o` is a single-cycle pulse. The results stay unchanged after it until the next accepted start.
- R12: `start_i` is ignored while `busy_o` is high. The fetch address sequence and the results of the instruction in progress are not affected.
- R13: The byte after a prefix is always the opcode, even if its bits 2:0 are 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin decoding at `pc_i` when idle |
| pc_i | input | ADDR_W | Address of the first instruction byte |
| mem_req_o | output | 1 | Byte read request |
| mem_addr_o | output | ADDR_W | Byte read address |
| mem_valid_i | input | 1 | Read data valid; a beat completes when request and valid are high |
| mem_data_i | input | 8 | Read data byte |
| opcode_valid_o | output | 1 | Opcode captured, table lookup may proceed |
| opcode_o | output | 8 | Opcode byte |
| mode_i | input | 3 | Addressing mode from the opcode table, valid while `opcode_valid_o` |
| idx_x_i | input | 8*MAX_BYTES | X index value |
| idx_y_i | input | 8*MAX_BYTES | Y index value |
| busy_o | output | 1 | Decode in progress |
| done_o | output | 1 | Results valid, one-cycle pulse |
| prefix_o | output | 8 | Prefix with marker bits cleared, 0 if absent |
| size_o | output | 4 | Operand size in bytes |
| operand_o | output | 8*MAX_BYTES | Operand or effective address |
| length_o | output | 5 | Instruction length in bytes |
| next_pc_o | output | ADDR_W | Address of the next instruction |

## Verification
A wrong first-byte classification shows within one fetch beat. The second request either appears at the wrong point or is missing, so the per-cycle address comparison catches it. The same comparison reports a lost, repeated or wrongly timed byte count on the very next request cycle. Wrong size decoding, wrong byte lane placement or a wrong index selection shows only at the `done_o` pulse, in `size_o`, `operand_o`, `length_o` or `next_pc_o`. Stalled beats and a start pulse that arrives mid-instruction are included, so that a counter that advances or reloads when it should not becomes visible.

// File: rtl/ipd_pkg.sv
package ipd_pkg;

  typedef enum logic [2:0] {
    AM_NONE = 3'd0,
    AM_IMM  = 3'd1,
    AM_ABS  = 3'd2,
    AM_ZM   = 3'd3,
    AM_ZMX  = 3'd4,
    AM_ZMY  = 3'd5
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_OPC,
    ST_MODE,
    ST_OPND,
    ST_DONE
  } dstate_e;

  localparam int unsigned ABS_BYTES = 8;
  localparam int unsigned ZM_BYTES  = 4;

  // operand bytes fetched for a mode and a decoded size
  function automatic int unsigned opnd_len(logic [2:0] mode, int unsigned size);
    case (amode_e'(mode))
      AM_IMM:               return size;
      AM_ABS:               return ABS_BYTES;
      AM_ZM, AM_ZMX, AM_ZMY: return ZM_BYTES;
      default:              return 0;
    endcase
  endfunction

endpackage

// File: rtl/ipd_first_byte.sv
module ipd_first_byte #(
  parameter int unsigned MARK_W = 3
) (
  input  logic [7:0] data_i,
  output logic       is_prefix_o,
  output logic [1:0] size_sel_o,
  output logic [7:0] stripped_o
);
  localparam logic [MARK_W-1:0] MARK = '1;

  assign is_prefix_o = (data_i[MARK_W-1:0] == MARK);
  assign size_sel_o  = data_i[5:4];
  assign stripped_o  = data_i - 8'(MARK);
endmodule

// File: rtl/ipd_operand_asm.sv
module ipd_operand_asm #(
  parameter  int unsigned MAX_BYTES = 8,
  localparam int unsigned CNT_W     = $clog2(MAX_BYTES + 1),
  localparam int unsigned W         = 8 * MAX_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [7:0]       data_i,
  input  logic [CNT_W-1:0] need_i,
  output logic [W-1:0]     raw_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (wr_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = wr_i && (cnt_q == need_i - 1'b1);

  // one register per byte lane, little-endian placement
  for (genvar g = 0; g < int'(MAX_BYTES); g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               lane_q <= '0;
      else if (clr_i)                            lane_q <= '0;
      else if (wr_i && cnt_q == CNT_W'(g))       lane_q <= data_i;
    end
    assign raw_o[8*g +: 8] = lane_q;
  end

  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= need_i);
  assert_no_extra_beat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> cnt_q < need_i);
endmodule

// File: rtl/ipd_ctrl.sv
module ipd_ctrl #(
  parameter  int unsigned ADDR_W    = 64,
  parameter  int unsigned MAX_BYTES = 8,
  localparam int unsigned CNT_W     = $clog2(MAX_BYTES + 1),
  localparam int unsigned SZ_W      = $clog2(MAX_BYTES) + 1,
  localparam int unsigned LEN_W     = $clog2(MAX_BYTES + 3) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              mem_valid_i,
  input  logic [7:0]        mem_data_i,
  input  logic [2:0]        mode_i,
  input  logic              is_prefix_i,
  input  logic [1:0]        size_sel_i,
  input  logic [7:0]        stripped_i,
  input  logic              last_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              asm_clr_o,
  output logic              asm_wr_o,
  output logic [CNT_W-1:0]  need_o,
  output logic              opcode_valid_o,
  output logic [7:0]        opcode_o,
  output logic [7:0]        prefix_o,
  output logic [SZ_W-1:0]   size_o,
  output logic [LEN_W-1:0]  length_o,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              busy_o,
  output logic              done_o
);
  import ipd_pkg::*;

  dstate_e           state_q;
  logic [ADDR_W-1:0] pc_q, addr_q;
  logic              has_pfx_q, opc_vld_q;
  logic [1:0]        size_sel_q;
  logic [7:0]        prefix_q, opcode_q;
  logic [CNT_W-1:0]  need_q, need_calc;
  logic [SZ_W-1:0]   size_bytes;
  logic              beat;

  assign size_bytes = SZ_W'(1) << size_sel_q;
  assign need_calc  = CNT_W'(opnd_len(mode_i, int'(size_bytes)));
  assign mem_req_o  = (state_q == ST_FIRST) || (state_q == ST_OPC) || (state_q == ST_OPND);
  assign beat       = mem_req_o && mem_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      pc_q       <= '0;
      addr_q     <= '0;
      has_pfx_q  <= 1'b0;
      opc_vld_q  <= 1'b0;
      size_sel_q <= '0;
      prefix_q   <= '0;
      opcode_q   <= '0;
      need_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          pc_q      <= pc_i;
          addr_q    <= pc_i;
          opc_vld_q <= 1'b0;
          state_q   <= ST_FIRST;
        end
        ST_FIRST: if (beat) begin
          addr_q <= addr_q + 1'b1;
          if (is_prefix_i) begin
            has_pfx_q  <= 1'b1;
            size_sel_q <= size_sel_i;
            prefix_q   <= stripped_i;
            state_q    <= ST_OPC;
          end else begin
            has_pfx_q  <= 1'b0;
            size_sel_q <= '0;
            prefix_q   <= '0;
            opcode_q   <= mem_data_i;
            opc_vld_q  <= 1'b1;
            state_q    <= ST_MODE;
          end
        end
        ST_OPC: if (beat) begin
          // the byte after a prefix is never reclassified
          addr_q    <= addr_q + 1'b1;
          opcode_q  <= mem_data_i;
          opc_vld_q <= 1'b1;
          state_q   <= ST_MODE;
        end
        ST_MODE: begin
          need_q  <= need_calc;
          state_q <= (need_calc == '0) ? ST_DONE : ST_OPND;
        end
        ST_OPND: if (beat) begin
          addr_q <= addr_q + 1'b1;
          if (last_i) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_addr_o     = addr_q;
  assign asm_clr_o      = (state_q == ST_MODE);
  assign asm_wr_o       = (state_q == ST_OPND) && beat;
  assign need_o         = need_q;
  assign opcode_valid_o = opc_vld_q;
  assign opcode_o       = opcode_q;
  assign prefix_o       = prefix_q;
  assign size_o         = size_bytes;
  assign length_o       = LEN_W'(has_pfx_q) + LEN_W'(1) + LEN_W'(need_q);
  assign next_pc_o      = pc_q + ADDR_W'(length_o);
  assign busy_o         = (state_q != ST_IDLE);
  assign done_o         = (state_q == ST_DONE);

  assert_addr_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o));
  assert_addr_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_valid_i |=> mem_addr_o == $past(mem_addr_o) + 1'b1);
  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_end_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> mem_addr_o == next_pc_o);
  assert_busy_start_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(pc_q));
endmodule

// File: rtl/insn_prefix_decoder.sv
module insn_prefix_decoder #(
  parameter  int unsigned ADDR_W    = 64,
  parameter  int unsigned MAX_BYTES = 8,
  localparam int unsigned OPND_W    = 8 * MAX_BYTES,
  localparam int unsigned CNT_W     = $clog2(MAX_BYTES + 1),
  localparam int unsigned SZ_W      = $clog2(MAX_BYTES) + 1,
  localparam int unsigned LEN_W     = $clog2(MAX_BYTES + 3) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [7:0]        mem_data_i,
  output logic              opcode_valid_o,
  output logic [7:0]        opcode_o,
  input  logic [2:0]        mode_i,
  input  logic [OPND_W-1:0] idx_x_i,
  input  logic [OPND_W-1:0] idx_y_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [7:0]        prefix_o,
  output logic [SZ_W-1:0]   size_o,
  output logic [OPND_W-1:0] operand_o,
  output logic [LEN_W-1:0]  length_o,
  output logic [ADDR_W-1:0] next_pc_o
);
  import ipd_pkg::*;

  logic              is_prefix, asm_clr, asm_wr, last;
  logic [1:0]        size_sel;
  logic [7:0]        stripped;
  logic [CNT_W-1:0]  need;
  logic [OPND_W-1:0] raw, idx_q;

  ipd_first_byte #(.MARK_W(3)) u_first (
    .data_i      (mem_data_i),
    .is_prefix_o (is_prefix),
    .size_sel_o  (size_sel),
    .stripped_o  (stripped)
  );

  ipd_ctrl #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .pc_i, .mem_valid_i, .mem_data_i, .mode_i,
    .is_prefix_i    (is_prefix),
    .size_sel_i     (size_sel),
    .stripped_i     (stripped),
    .last_i         (last),
    .mem_req_o, .mem_addr_o,
    .asm_clr_o      (asm_clr),
    .asm_wr_o       (asm_wr),
    .need_o         (need),
    .opcode_valid_o, .opcode_o, .prefix_o, .size_o, .length_o, .next_pc_o,
    .busy_o, .done_o
  );

  ipd_operand_asm #(.MAX_BYTES(MAX_BYTES)) u_asm (
    .clk_i, .rst_ni,
    .clr_i  (asm_clr),
    .wr_i   (asm_wr),
    .data_i (mem_data_i),
    .need_i (need),
    .raw_o  (raw),
    .last_o (last)
  );

  // index captured with the mode so it need not be held afterwards
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else if (asm_clr) begin
      case (amode_e'(mode_i))
        AM_ZMX:  idx_q <= idx_x_i;
        AM_ZMY:  idx_q <= idx_y_i;
        default: idx_q <= '0;
      endcase
    end
  end

  assign operand_o = raw + idx_q;

  assert_result_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(operand_o) && $stable(next_pc_o) && $stable(length_o));
  assert_idle_no_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !done_o);
endmodule

// File: tb/insn_prefix_decoder_bench.sv
`timescale 1ns/1ps
module insn_prefix_decoder_bench;
  localparam int unsigned AW = 64;
  localparam int unsigned OW = 64;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] pc_i = '0;
  logic          mem_req_o;
  logic [AW-1:0] mem_addr_o;
  logic          mem_valid_i = 1'b0;
  logic [7:0]    mem_data_i = '0;
  logic          opcode_valid_o;
  logic [7:0]    opcode_o;
  logic [2:0]    mode_i = '0;
  logic [OW-1:0] idx_x_i = '0, idx_y_i = '0;
  logic          busy_o, done_o;
  logic [7:0]    prefix_o;
  logic [3:0]    size_o;
  logic [OW-1:0] operand_o;
  logic [4:0]    length_o;
  logic [AW-1:0] next_pc_o;

  logic [7:0]    mem [256];
  logic [63:0]   exp_addr [$];
  int            n_vec = 0, n_err = 0, cyc = 0;
  bit            stall_en = 1'b0;

  always #2 clk = ~clk;

  insn_prefix_decoder u_insn_prefix_decoder (
    .clk_i(clk), .rst_ni, .start_i, .pc_i, .mem_req_o, .mem_addr_o, .mem_valid_i,
    .mem_data_i, .opcode_valid_o, .opcode_o, .mode_i, .idx_x_i, .idx_y_i,
    .busy_o, .done_o, .prefix_o, .size_o, .operand_o, .length_o, .next_pc_o
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory model and per-cycle fetch address comparison (R10)
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_vec++; n_err++;
      $display("FAIL watchdog R10 act=%0d exp=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
    mem_valid_i = 1'b0;
    mem_data_i  = '0;
    if (rst_ni && mem_req_o) begin
      if (exp_addr.size() == 0) chk("R10 unexpected request", mem_addr_o, 64'hFFFF_FFFF_FFFF_FFFF);
      else begin
        chk("R10 fetch address", mem_addr_o, exp_addr[0]);
        if (!(stall_en && (cyc % 3 != 0))) begin
          mem_valid_i = 1'b1;
          mem_data_i  = mem[mem_addr_o[7:0]];
          void'(exp_addr.pop_front());
        end
      end
    end
  end

  task automatic run_insn(input string nm, input logic [63:0] pc, input int nb,
                          input logic [79:0] bytes, input logic [2:0] mode,
                          input logic [63:0] x, input logic [63:0] y,
                          input bit stall, input bit spur);
    logic [63:0] p, raw, oper, npc;
    logic [7:0]  f, op, pre;
    int          sz, n, len, pf, t;
    for (int k = 0; k < nb; k++) mem[8'(pc + 64'(k))] = bytes[8*k +: 8];
    f = mem[pc[7:0]];
    p = pc;
    if (f[2:0] == 3'b111) begin pf = 1; sz = 1 << f[5:4]; pre = f - 8'd7; p++; end
    else begin pf = 0; sz = 1; pre = 8'h00; end
    op = mem[p[7:0]];
    p++;
    case (mode)
      3'd1: n = sz;
      3'd2: n = 8;
      3'd3, 3'd4, 3'd5: n = 4;
      default: n = 0;
    endcase
    raw = '0;
    for (int k = 0; k < n; k++) raw = raw | (64'(mem[8'(p + 64'(k))]) << (8 * k));
    oper = raw + ((mode == 3'd4) ? x : (mode == 3'd5) ? y : 64'd0);
    len  = pf + 1 + n;
    npc  = pc + 64'(len);
    for (int k = 0; k < len; k++) exp_addr.push_back(pc + 64'(k));

    stall_en = stall;
    mode_i = mode; idx_x_i = x; idx_y_i = y;
    @(negedge clk); start_i = 1'b1; pc_i = pc;
    @(negedge clk); start_i = 1'b0; pc_i = '0;
    if (spur) begin
      @(negedge clk); start_i = 1'b1; pc_i = 64'h10;   // R12: must be ignored
      @(negedge clk); start_i = 1'b0; pc_i = '0;
    end
    t = 0;
    while (!done_o && t < 300) begin @(negedge clk); t++; end
    chk({nm, " R11 done seen"}, 64'(done_o), 64'd1);
    chk({nm, " R2 R13 opcode"}, 64'(opcode_o), 64'(op));
    chk({nm, " R3 R4 size"}, 64'(size_o), 64'(sz));
    chk({nm, " R5 prefix"}, 64'(prefix_o), 64'(pre));
    chk({nm, " R6 R7 R8 operand"}, operand_o, oper);
    chk({nm, " R9 length"}, 64'(length_o), 64'(len));
    chk({nm, " R9 next pc"}, next_pc_o, npc);
    chk({nm, " R10 all bytes fetched"}, 64'(exp_addr.size()), 64'd0);
    chk({nm, " R12 opcode valid"}, 64'(opcode_valid_o), 64'd1);
    @(negedge clk);
    chk({nm, " R11 done pulse"}, 64'(done_o), 64'd0);
    chk({nm, " R11 operand held"}, operand_o, oper);
    chk({nm, " R11 next pc held"}, next_pc_o, npc);
    stall_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 64'(busy_o), 64'd0);
    chk("R1 done in reset", 64'(done_o), 64'd0);
    chk("R1 req in reset", 64'(mem_req_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 req after reset", 64'(mem_req_o), 64'd0);
    chk("R1 opcode valid after reset", 64'(opcode_valid_o), 64'd0);

    // mode codes: 0 none, 1 imm, 2 abs, 3 zm, 4 zm+X, 5 zm+Y
    run_insn("R3 none",    64'h10, 1, 80'h10, 3'd0, 0, 0, 0, 0);
    run_insn("R3 imm1",    64'h20, 2, 80'h05A9, 3'd1, 0, 0, 1, 0);
    run_insn("R4 pfx17",   64'h30, 4, 80'h1234A917, 3'd1, 0, 0, 0, 0);
    run_insn("R4 pfx27",   64'h40, 6, 80'h12345678A927, 3'd1, 0, 0, 1, 0);
    run_insn("R4 pfx37",   64'h50, 10, 80'h1122334455667788_A937, 3'd1, 0, 0, 0, 0);
    run_insn("R2 pfx07",   64'h60, 3, 80'h5AA907, 3'd1, 0, 0, 0, 0);
    run_insn("R7 abs",     64'h70, 9, 80'h0F0E0D0C0B0A0908_4C, 3'd2, 0, 0, 1, 0);
    run_insn("R8 zm",      64'h80, 5, 80'h1122334485, 3'd3, 64'h55, 64'h66, 0, 0);
    run_insn("R8 zmx",     64'h88, 5, 80'hFFFFFFFF95, 3'd4, 64'h1_0000_0001, 64'h7, 1, 0);
    run_insn("R8 zmy",     64'h90, 5, 80'h000000F0B5, 3'd5, 64'h9, 64'h10, 0, 0);
    run_insn("R13 opc111", 64'hA0, 4, 80'h11220F17, 3'd1, 0, 0, 0, 0);
    run_insn("R5 pfxF7",   64'hA8, 2, 80'hEAF7, 3'd0, 0, 0, 0, 0);
    run_insn("R6 mode6",   64'hB0, 3, 80'h777701, 3'd6, 0, 0, 0, 0);
    run_insn("R12 spur",   64'hB8, 10, 80'hF1E2D3C4B5A69788_6C17, 3'd2, 0, 0, 1, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule